// File: doc/BRIEF.md
# Cascaded Two-Stage Interval Timer

This block divides a slow auxiliary timebase through two cascaded 8-bit counters. It produces two outputs: a square wave at a selectable rate for a display controller, and an interval interrupt. Both counters run in the single system clock domain. They advance only on one-cycle strobes (`aux_stb`, `fast_stb`), so no clock is ever derived from a counter bit.

The first stage counts auxiliary strobes and acts as a prescaler. Its wrap, which is the auxiliary rate divided by 256, can feed the second stage. When that path is not chosen, the second stage counts either auxiliary or fast strobes. A 3-bit tap select on the second stage sets the interval. Each completed interval sets a sticky flag. The flag drives the interrupt request only while the interrupt enable bit is set. Software configures the block through one 8-bit control register and a separate enable bit. It clears the flag with a write-one strobe.

Top module: `ivt_top`

## Requirements
- R1: After a synchronous active-low reset, the following are all zero: both counters, the control register, the interrupt enable, the flag, `disp_clk` and `int_req`.
- R2: A `ctrl_we` strobe loads `ctrl_wdata` into the control register, and `ctrl_q` shows it from the next cycle. A write never resets either counter. The control fields are: bit 7 source select (0 auxiliary, 1 fast), bit 6 hold, bit 5 cascade, bits 4:3 display rate, bits 2:0 interval.
- R3: The first stage advances by one on each `aux_stb` cycle. The exception is when hold and cascade are both 1: then it keeps its value.
- R4: With cascade at 1, the second stage advances once per 256 auxiliary strobes, on the strobe that wraps the first stage from 255 to 0.
- R5: With cascade at 0, the second stage counts `aux_stb` when the source select is 0 and `fast_stb` when it is 1. The strobe that is not selected has no effect.
- R6: With hold at 1, the second stage does not advance, whatever the source.
- R7: Interval code k (0 to 7) marks an event on every 2^(k+1)-th advance of the second stage, at the advance where second-stage bit k falls from 1 to 0.
- R8: An interval event sets `int_flag` at that clock edge. The flag stays set until a `flag_clr` strobe. If an event and a clear land on the same cycle, the flag ends up set.
- R9: `int_req` is high exactly when `int_flag` and the interrupt enable (written with `irq_en_we`/`irq_en_wdata`) are both set.
- R10: `disp_clk` equals first-stage bit 4+c for display code c. This gives the auxiliary rate divided by 32, 64, 128 or 256 for codes 00, 01, 10 and 11. While the first stage is frozen, `disp_clk` holds its level.
- R11: From reset, with control value 0x23 (cascade, interval code 3), the flag rises on the 4096th auxiliary strobe and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| aux_stb | input | 1 | One-cycle auxiliary timebase strobe |
| fast_stb | input | 1 | One-cycle fast timebase strobe |
| ctrl_we | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write data |
| irq_en_we | input | 1 | Interrupt enable write strobe |
| irq_en_wdata | input | 1 | Interrupt enable write value |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| ctrl_q | output | 8 | Control register contents |
| disp_clk | output | 1 | Display-rate square wave |
| int_flag | output | 1 | Sticky interval flag |
| int_req | output | 1 | Gated interrupt request |

## Verification
The bench uses the default stage width of 8. At that width the full cascade period of 4096 auxiliary strobes takes only a few thousand cycles, and every display tap and interval tap from divide-by-2 up to divide-by-256 can be reached. Because both counters wrap at 256, the sequence also passes through first-stage wraps under each source select and under the hold combinations. A behavioural model of the count values predicts the flag, request and display level after every strobe.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  typedef struct packed {
    logic       src_fast;
    logic       hold;
    logic       cascade;
    logic [1:0] drate;
    logic [2:0] ival;
  } ivt_ctrl_t;

  localparam int CTRL_W = $bits(ivt_ctrl_t);
endpackage

// File: rtl/ivt_stage.sv
module ivt_stage #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         adv,
  output logic [W-1:0] count,
  output logic         wrap
);
  always_ff @(posedge clk) begin
    if (!rst_n)   count <= '0;
    else if (adv) count <= count + 1'b1;
  end

  assign wrap = adv && (&count);
endmodule

// File: rtl/ivt_src_sel.sv
module ivt_src_sel
  import ivt_pkg::*;
(
  input  ivt_ctrl_t ctrl,
  input  logic      aux_stb,
  input  logic      fast_stb,
  input  logic      s1_wrap,
  output logic      s1_adv,
  output logic      s2_adv
);
  logic frz_both;
  logic s2_src;

  assign frz_both = ctrl.hold && ctrl.cascade;
  assign s1_adv   = aux_stb && !frz_both;

  always_comb begin
    if (ctrl.cascade)       s2_src = s1_wrap;
    else if (ctrl.src_fast) s2_src = fast_stb;
    else                    s2_src = aux_stb;
  end

  assign s2_adv = s2_src && !ctrl.hold;
endmodule

// File: rtl/ivt_ival_det.sv
module ivt_ival_det #(
  parameter int W = 8,
  localparam int SW = $clog2(W)
) (
  input  logic          adv,
  input  logic [W-1:0]  count,
  input  logic [SW-1:0] sel,
  output logic          evt
);
  logic [W-1:0] mask;

  for (genvar i = 0; i < W; i++) begin : g_mask
    assign mask[i] = (i <= int'(sel));
  end

  // selected bit falls when all bits up to it are ones and the stage advances
  assign evt = adv && (&(count | ~mask));
endmodule

// File: rtl/ivt_top.sv
module ivt_top
  import ivt_pkg::*;
#(
  parameter int CNT_W = 8,
  localparam int DBASE = CNT_W - 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              aux_stb,
  input  logic              fast_stb,
  input  logic              ctrl_we,
  input  logic [CTRL_W-1:0] ctrl_wdata,
  input  logic              irq_en_we,
  input  logic              irq_en_wdata,
  input  logic              flag_clr,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              disp_clk,
  output logic              int_flag,
  output logic              int_req
);
  ivt_ctrl_t        ctrl_r;
  logic             irq_en;
  logic             flag_r;
  logic             s1_adv, s2_adv, s1_wrap, s2_wrap;
  logic [CNT_W-1:0] cnt1, cnt2;
  logic             ival_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)       ctrl_r <= '0;
    else if (ctrl_we) ctrl_r <= ivt_ctrl_t'(ctrl_wdata);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         irq_en <= 1'b0;
    else if (irq_en_we) irq_en <= irq_en_wdata;
  end

  ivt_src_sel u_sel (
    .ctrl    (ctrl_r),
    .aux_stb (aux_stb),
    .fast_stb(fast_stb),
    .s1_wrap (s1_wrap),
    .s1_adv  (s1_adv),
    .s2_adv  (s2_adv)
  );

  ivt_stage #(.W(CNT_W)) u_s1 (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (s1_adv),
    .count(cnt1),
    .wrap (s1_wrap)
  );

  ivt_stage #(.W(CNT_W)) u_s2 (
    .clk  (clk),
    .rst_n(rst_n),
    .adv  (s2_adv),
    .count(cnt2),
    .wrap (s2_wrap)
  );

  ivt_ival_det #(.W(CNT_W)) u_det (
    .adv  (s2_adv),
    .count(cnt2),
    .sel  (ctrl_r.ival[$clog2(CNT_W)-1:0]),
    .evt  (ival_evt)
  );

  // event wins over a same-cycle clear
  always_ff @(posedge clk) begin
    if (!rst_n) flag_r <= 1'b0;
    else        flag_r <= ival_evt || (flag_r && !flag_clr);
  end

  assign disp_clk = cnt1[DBASE + int'(ctrl_r.drate)];
  assign ctrl_q   = ctrl_r;
  assign int_flag = flag_r;
  assign int_req  = flag_r && irq_en;
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ctrl_we,
  input logic             flag_clr,
  input logic [7:0]       ctrl_q,
  input logic             disp_clk,
  input logic             int_flag,
  input logic             int_req,
  input logic [CNT_W-1:0] cnt1,
  input logic [CNT_W-1:0] cnt2
);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_flag && !flag_clr |=> int_flag);

  // R9
  req_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int_req |-> int_flag);

  // R6
  s2_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6] |=> $stable(cnt2));

  // R3
  s1_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6] && ctrl_q[5] |=> $stable(cnt1));

  // R10
  disp_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_q[6] && ctrl_q[5] && !ctrl_we |=> $stable(disp_clk));

  // R7
  evt_on_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(int_flag) |-> cnt2 != $past(cnt2));
endmodule

bind ivt_top ivt_chk #(.CNT_W(CNT_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .ctrl_we (ctrl_we),
  .flag_clr(flag_clr),
  .ctrl_q  (ctrl_q),
  .disp_clk(disp_clk),
  .int_flag(int_flag),
  .int_req (int_req),
  .cnt1    (cnt1),
  .cnt2    (cnt2)
);

// File: tb/tb_ivt_top.sv
module tb_ivt_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       aux_stb = 1'b0, fast_stb = 1'b0;
  logic       ctrl_we = 1'b0, irq_en_we = 1'b0, irq_en_wdata = 1'b0, flag_clr = 1'b0;
  logic [7:0] ctrl_wdata = '0;
  logic [7:0] ctrl_q;
  logic       disp_clk, int_flag, int_req;

  always #2.5 clk = ~clk;

  ivt_top dut (
    .clk(clk), .rst_n(rst_n), .aux_stb(aux_stb), .fast_stb(fast_stb),
    .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata), .irq_en_we(irq_en_we),
    .irq_en_wdata(irq_en_wdata), .flag_clr(flag_clr), .ctrl_q(ctrl_q),
    .disp_clk(disp_clk), .int_flag(int_flag), .int_req(int_req)
  );

  typedef struct {string req; int sig; int exp;} item_t;
  item_t q[$];
  int n_vec = 0, n_bad = 0;
  int m1 = 0, m2 = 0;
  bit mflag = 0, men = 0;
  logic [7:0] mctrl = '0;
  string cur = "R1";
  bit done = 0;

  function automatic void push(string r, int s, int e);
    item_t it;
    it.req = r; it.sig = s; it.exp = e;
    q.push_back(it);
  endfunction

  function automatic void push_all();
    int fq;
    fq = int'(mctrl[4:3]);
    push(cur, 0, int'(mflag));
    push((cur == "R1") ? "R1" : "R9", 1, int'(mflag && men));
    push((cur == "R1") ? "R1" : "R10", 2, (m1 >> (4 + fq)) & 1);
    push((cur == "R1") ? "R1" : "R2", 3, int'(mctrl));
  endfunction

  task automatic step(bit a, bit f, bit c);
    bit hold, dv, sel, run1, ovf, src, run2, evt;
    int per;
    @(negedge clk);
    aux_stb = a; fast_stb = f; flag_clr = c;
    @(posedge clk); #1;
    aux_stb = 0; fast_stb = 0; flag_clr = 0;
    hold = mctrl[6]; dv = mctrl[5]; sel = mctrl[7];
    per  = 2 << int'(mctrl[2:0]);
    run1 = a && !(hold && dv);
    ovf  = run1 && (m1 == 255);
    src  = dv ? ovf : (sel ? f : a);
    run2 = src && !hold;
    evt  = run2 && ((m2 % per) == per - 1);
    mflag = evt || (mflag && !c);
    if (run1) m1 = (m1 + 1) % 256;
    if (run2) m2 = (m2 + 1) % 256;
    push_all();
  endtask

  task automatic wr_ctrl(logic [7:0] v);
    @(negedge clk);
    ctrl_we = 1; ctrl_wdata = v;
    @(posedge clk); #1;
    ctrl_we = 0;
    mctrl = v;
    push_all();
  endtask

  task automatic wr_en(bit b);
    @(negedge clk);
    irq_en_we = 1; irq_en_wdata = b;
    @(posedge clk); #1;
    irq_en_we = 0;
    men = b;
    push_all();
  endtask

  // monitor: compares queued expectations away from the active edge
  always @(negedge clk) begin
    while (q.size() > 0) begin
      item_t it;
      int act;
      it = q.pop_front();
      case (it.sig)
        0: act = int'(int_flag);
        1: act = int'(int_req);
        2: act = int'(disp_clk);
        default: act = int'(ctrl_q);
      endcase
      n_vec++;
      if (act != it.exp) begin
        n_bad++;
        $display("FAIL %s sig%0d actual=%0d expected=%0d at %0t", it.req, it.sig, act, it.exp, $time);
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(posedge clk); #1;
    cur = "R1"; push_all();

    // R11: 4096 auxiliary strobes in cascade with interval code 3
    cur = "R11";
    wr_ctrl(8'h23);
    for (int i = 0; i < 4096; i++) step(1, 0, 0);

    // R8: clear, then events coinciding with clear strobes
    cur = "R8";
    step(0, 0, 1);
    wr_ctrl(8'h00);
    for (int i = 0; i < 6; i++) step(1, 0, 1);
    step(0, 0, 0);

    // R9: enable gating
    cur = "R9";
    wr_en(1);
    step(0, 0, 1);
    for (int i = 0; i < 3; i++) step(1, 0, 0);
    wr_en(0);
    step(1, 0, 0);

    // R5: fast source, aux ignored; then aux source, fast ignored
    cur = "R5";
    wr_ctrl(8'h82);
    step(0, 0, 1);
    for (int i = 0; i < 10; i++) step(1, 0, 0);
    for (int i = 0; i < 20; i++) step(0, 1, (i == 9));
    wr_ctrl(8'h01);
    step(0, 0, 1);
    for (int i = 0; i < 10; i++) step(0, 1, 0);
    for (int i = 0; i < 10; i++) step(1, 0, (i == 4));

    // R6: hold without cascade stops stage two only
    cur = "R6";
    wr_ctrl(8'h40);
    step(0, 0, 1);
    for (int i = 0; i < 40; i++) step(1, 1, 0);

    // R3: hold with cascade freezes both stages and the display output
    cur = "R3";
    wr_ctrl(8'h78);
    for (int i = 0; i < 20; i++) step(1, 1, 0);

    // R10: display taps
    cur = "R10";
    wr_ctrl(8'h18);
    for (int i = 0; i < 300; i++) step(1, 0, 1);
    wr_ctrl(8'h08);
    for (int i = 0; i < 130; i++) step(1, 0, 1);

    // R4: cascade path, fast strobes ignored
    cur = "R4";
    wr_ctrl(8'h20);
    step(0, 0, 1);
    for (int i = 0; i < 600; i++) step(1, (i % 3 == 0), (i % 256 == 100));

    // R7: widest interval tap on auxiliary strobes
    cur = "R7";
    wr_ctrl(8'h07);
    step(0, 0, 1);
    for (int i = 0; i < 300; i++) step(1, 0, (i == 200));

    cur = "R2";
    wr_ctrl(8'hA5);
    step(0, 0, 0);

    @(negedge clk); @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule